// File: doc/BRIEF.md
# Boot Region Lockout Guard

This block guards the two boot regions of a byte-addressed flash array: the lowest 16 KB and the highest 16 KB. Each region has its own lock flag. A flag is set by a fixed seven-command activation sequence that arrives on a load-command stream. The final command of that sequence chooses which region is locked. Once a flag is set, it stays set until the power-on reset input is asserted again.

The program controller presents every sector program or erase request, and every whole-chip erase request, to the guard. The guard answers in the same cycle with a grant. A request is refused when it targets a locked region. A whole-chip erase is refused when either region is locked.

While the identification-mode input is high, two fixed read addresses return the status byte of a region in place of array data. These are 00002h for the lower region and 7FFF2h for the upper region. The surrounding read path drives the identification-mode input and clears it on the exit command, which returns reads to array data.

The command stream uses a valid/ready handshake. The guard never applies back-pressure: ready is held high, so every command offered is consumed on the clock edge where valid is high.

Top module: `boot_lockout`

## Requirements
- R1: After reset both lock flags are clear: every sector request and a chip-erase request are granted, and both status reads return FEh.
- R2: `cmd_ready` is always high; a command is consumed on every rising edge with `cmd_valid` high.
- R3: The activation sequence is seven commands (address, data), in this order: (5555h,AAh), (2AAAh,55h), (5555h,80h), (5555h,AAh), (2AAAh,55h), (5555h,40h), (5555h, selector). Selector 00h locks the lower region; selector FFh locks the upper region. The flag is visible from the edge that consumes the seventh command.
- R4: A command that does not match the expected step returns the sequence to its start and is itself discarded, so no lock results from a broken sequence.
- R5: The two flags are independent: locking one region leaves the other region's requests and status unchanged.
- R6: A locked lower region refuses sectors 0 to 63 and still grants sector 64. A locked upper region refuses sectors 1984 to 2047 and still grants sector 1983. Sectors are 256 bytes.
- R7: A chip-erase request (`req_chip` high) is refused whenever either flag is set.
- R8: With `id_mode` high, address 00002h returns the lower status and address 7FFF2h returns the upper status, with `id_hit` high. The status byte is FEh when the region is programmable and FFh when it is locked.
- R9: With `id_mode` low, or at any other address, `id_hit` and `id_data` are zero.
- R10: A set flag is never cleared by any command, including a repeated or corrupted sequence. A seventh command whose selector is neither 00h nor FFh sets nothing. Only reset clears the flags.
- R11: `req_grant` is low whenever `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; the only way to clear the flags |
| cmd_valid | input | 1 | Load command offered |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_addr | input | ADDR_W | Load command address |
| cmd_data | input | 8 | Load command data |
| req_valid | input | 1 | Program/erase request present |
| req_chip | input | 1 | Request is a whole-chip erase |
| req_sector | input | ADDR_W-8 | Sector targeted by the request |
| req_grant | output | 1 | Request allowed (combinational) |
| id_mode | input | 1 | Identification read mode active |
| rd_addr | input | ADDR_W | Read address |
| id_hit | output | 1 | Read address is a status location in identification mode |
| id_data | output | 8 | Status byte when `id_hit` is high, else zero |

## Verification
The bench builds the block with its default parameters. These are a 19-bit address, 256-byte sectors and 16 KB regions, which give 2048 sectors with 64-sector boot regions, together with the default activation codes. At these values the region edges at sectors 63/64 and 1983/1984 and the status addresses 00002h and 7FFF2h can be exercised exactly at their true positions. The same values also allow a broken sequence to be built whose tail resembles a fresh start, which checks how the sequence resets on a mismatch.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;
  localparam int unsigned SEQ_LEN = 7;
  localparam int unsigned DATA_W  = 8;

  typedef struct packed {
    logic lo;
    logic hi;
  } lock_pair_t;
endpackage

// File: rtl/bootlock_seq.sv
module bootlock_seq
  import bootlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ_ADDR = '0,
  parameter logic [(SEQ_LEN-1)*DATA_W-1:0] SEQ_DATA = '0,
  parameter logic [DATA_W-1:0] SEL_LO = 8'h00,
  parameter logic [DATA_W-1:0] SEL_HI = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output lock_pair_t        set_req
);
  localparam int unsigned STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0]  step;
  logic [SEQ_LEN-1:0] hit;

  // one comparator per step; the last step checks only the address
  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_step
    if (g < SEQ_LEN - 1) begin : g_full
      assign hit[g] = (addr == SEQ_ADDR[g*ADDR_W +: ADDR_W]) &&
                      (data == SEQ_DATA[g*DATA_W +: DATA_W]);
    end else begin : g_tail
      assign hit[g] = (addr == SEQ_ADDR[g*ADDR_W +: ADDR_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
    end else if (accept) begin
      if (step == LAST || !hit[step]) step <= '0;
      else                            step <= step + 1'b1;
    end
  end

  always_comb begin
    set_req = '0;
    if (accept && step == LAST && hit[LAST]) begin
      set_req.lo = (data == SEL_LO);
      set_req.hi = (data == SEL_HI);
    end
  end
endmodule

// File: rtl/bootlock_store.sv
module bootlock_store
  import bootlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lock_pair_t set_req,
  output lock_pair_t locks
);
  // one-way flags: only reset clears them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locks <= '0;
    else        locks <= locks | set_req;
  end
endmodule

// File: rtl/bootlock_gate.sv
module bootlock_gate
  import bootlock_pkg::*;
#(
  parameter int unsigned SECT_W   = 11,
  parameter int unsigned REG_SECT = 64
) (
  input  lock_pair_t        locks,
  input  logic              req_valid,
  input  logic              req_chip,
  input  logic [SECT_W-1:0] req_sector,
  output logic              req_grant
);
  localparam logic [SECT_W-1:0] LO_END  = SECT_W'(REG_SECT);
  localparam logic [SECT_W-1:0] HI_BASE = SECT_W'((1 << SECT_W) - REG_SECT);

  logic in_lo, in_hi, blocked;

  assign in_lo = (req_sector < LO_END);
  assign in_hi = (req_sector >= HI_BASE);

  always_comb begin
    if (req_chip) blocked = locks.lo | locks.hi;
    else          blocked = (in_lo & locks.lo) | (in_hi & locks.hi);
  end

  assign req_grant = req_valid & ~blocked;
endmodule

// File: rtl/bootlock_idread.sv
module bootlock_idread
  import bootlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  lock_pair_t        locks,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_hit,
  output logic [DATA_W-1:0] id_data
);
  localparam logic [ADDR_W-1:0] LO_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] HI_STAT = ~ADDR_W'(13);

  always_comb begin
    id_hit  = 1'b0;
    id_data = '0;
    if (id_mode && rd_addr == LO_STAT) begin
      id_hit  = 1'b1;
      id_data = {7'h7F, locks.lo};
    end else if (id_mode && rd_addr == HI_STAT) begin
      id_hit  = 1'b1;
      id_data = {7'h7F, locks.hi};
    end
  end
endmodule

// File: rtl/boot_lockout.sv
module boot_lockout
  import bootlock_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned SECTOR_BYTES = 256,
  parameter int unsigned REGION_BYTES = 16384,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ_ADDR =
    {19'h05555, 19'h05555, 19'h02AAA, 19'h05555,
     19'h05555, 19'h02AAA, 19'h05555},
  parameter logic [(SEQ_LEN-1)*DATA_W-1:0] SEQ_DATA =
    {8'h40, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA},
  parameter logic [DATA_W-1:0] SEL_LO = 8'h00,
  parameter logic [DATA_W-1:0] SEL_HI = 8'hFF,
  localparam int unsigned SECT_W   = ADDR_W - $clog2(SECTOR_BYTES),
  localparam int unsigned REG_SECT = REGION_BYTES / SECTOR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              req_valid,
  input  logic              req_chip,
  input  logic [SECT_W-1:0] req_sector,
  output logic              req_grant,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_hit,
  output logic [DATA_W-1:0] id_data
);
  lock_pair_t set_req, locks;
  logic lock_lo, lock_hi;

  assign cmd_ready = 1'b1;
  assign lock_lo   = locks.lo;
  assign lock_hi   = locks.hi;

  bootlock_seq #(
    .ADDR_W(ADDR_W), .SEQ_ADDR(SEQ_ADDR), .SEQ_DATA(SEQ_DATA),
    .SEL_LO(SEL_LO), .SEL_HI(SEL_HI)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(cmd_valid & cmd_ready),
    .addr(cmd_addr), .data(cmd_data), .set_req(set_req)
  );

  bootlock_store u_store (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .locks(locks)
  );

  bootlock_gate #(.SECT_W(SECT_W), .REG_SECT(REG_SECT)) u_gate (
    .locks(locks), .req_valid(req_valid), .req_chip(req_chip),
    .req_sector(req_sector), .req_grant(req_grant)
  );

  bootlock_idread #(.ADDR_W(ADDR_W)) u_id (
    .locks(locks), .id_mode(id_mode), .rd_addr(rd_addr),
    .id_hit(id_hit), .id_data(id_data)
  );
endmodule

// File: rtl/bootlock_chk.sv
module bootlock_chk #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned SECT_W   = 11,
  parameter int unsigned REG_SECT = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              req_valid,
  input logic              req_chip,
  input logic [SECT_W-1:0] req_sector,
  input logic              req_grant,
  input logic              id_mode,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              id_hit,
  input logic [7:0]        id_data,
  input logic              lock_lo,
  input logic              lock_hi
);
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready);

  p_set_by_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_lo) || $rose(lock_hi)) |-> $past(cmd_valid));

  p_lo_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_chip && lock_lo && req_sector < SECT_W'(REG_SECT)) |-> !req_grant);

  p_hi_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_chip && lock_hi &&
     req_sector >= SECT_W'((1 << SECT_W) - REG_SECT)) |-> !req_grant);

  p_chip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_chip && (lock_lo || lock_hi)) |-> !req_grant);

  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && rd_addr == ADDR_W'(2)) |-> (id_hit && id_data == {7'h7F, lock_lo}));

  p_idoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> (!id_hit && id_data == 8'h00));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(lock_lo) && !$fell(lock_hi));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_grant);
endmodule

bind boot_lockout bootlock_chk u_chk (.*);

// File: tb/test_boot_lockout.sv
module test_boot_lockout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [18:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        req_valid = 1'b0;
  logic        req_chip = 1'b0;
  logic [10:0] req_sector = '0;
  logic        req_grant;
  logic        id_mode = 1'b0;
  logic [18:0] rd_addr = '0;
  logic        id_hit;
  logic [7:0]  id_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  boot_lockout i_boot_lockout (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
    #1 chk(cmd_ready == 1'b1, "R2 ready", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // R3 activation steps
  task automatic run_seq(input logic [7:0] sel);
    send(19'h05555, 8'hAA); send(19'h02AAA, 8'h55); send(19'h05555, 8'h80);
    send(19'h05555, 8'hAA); send(19'h02AAA, 8'h55); send(19'h05555, 8'h40);
    send(19'h05555, sel);
  endtask

  task automatic grant_of(input bit chip, input logic [10:0] s, output bit g);
    @(negedge clk);
    req_valid = 1'b1; req_chip = chip; req_sector = s;
    #1 g = req_grant;
    req_valid = 1'b0; req_chip = 1'b0;
  endtask

  task automatic id_read(input bit mode, input logic [18:0] a,
                         output bit h, output logic [7:0] d);
    @(negedge clk);
    id_mode = mode; rd_addr = a;
    #1 h = id_hit; d = id_data;
    id_mode = 1'b0;
  endtask

  task automatic expect_grant(input bit chip, input logic [10:0] s,
                              input bit exp, input string req);
    bit g;
    grant_of(chip, s, g);
    chk(g == exp, req, int'(g), int'(exp));
  endtask

  task automatic expect_stat(input logic [18:0] a, input logic [7:0] exp, input string req);
    bit h; logic [7:0] d;
    id_read(1'b1, a, h, d);
    chk(h && d == exp, req, int'(d), int'(exp));
  endtask

  task automatic t_reset;
    expect_grant(1'b0, 11'd0, 1'b1, "R1 sector 0");
    expect_grant(1'b0, 11'd2047, 1'b1, "R1 sector 2047");
    expect_grant(1'b1, 11'd0, 1'b1, "R1 chip erase");
    expect_stat(19'h00002, 8'hFE, "R1 lower status");
    expect_stat(19'h7FFF2, 8'hFE, "R1 upper status");
    @(negedge clk);
    req_sector = 11'd100;
    #1 chk(req_grant == 1'b0, "R11 idle grant", int'(req_grant), 0);
  endtask

  task automatic t_broken;
    send(19'h05555, 8'hAA); send(19'h02AAA, 8'h55); send(19'h05555, 8'h80);
    send(19'h05555, 8'h13);
    send(19'h05555, 8'hAA); send(19'h02AAA, 8'h55); send(19'h05555, 8'h40);
    send(19'h05555, 8'h00);
    expect_stat(19'h00002, 8'hFE, "R4 broken sequence");
    expect_grant(1'b0, 11'd0, 1'b1, "R4 sector 0 still open");
    run_seq(8'h5A);
    expect_stat(19'h00002, 8'hFE, "R10 bad selector lower");
    expect_stat(19'h7FFF2, 8'hFE, "R10 bad selector upper");
  endtask

  task automatic t_lock_lo;
    run_seq(8'h00);
    expect_stat(19'h00002, 8'hFF, "R3 R8 lower locked");
    expect_stat(19'h7FFF2, 8'hFE, "R5 upper untouched");
    expect_grant(1'b0, 11'd0, 1'b0, "R6 sector 0");
    expect_grant(1'b0, 11'd63, 1'b0, "R6 sector 63");
    expect_grant(1'b0, 11'd64, 1'b1, "R6 sector 64");
    expect_grant(1'b0, 11'd2047, 1'b1, "R5 sector 2047");
    expect_grant(1'b1, 11'd0, 1'b0, "R7 chip erase lower");
  endtask

  task automatic t_id_gate;
    bit h; logic [7:0] d;
    id_read(1'b0, 19'h00002, h, d);
    chk(!h && d == 8'h00, "R9 mode off", int'(d), 0);
    id_read(1'b1, 19'h00003, h, d);
    chk(!h && d == 8'h00, "R9 other address", int'(d), 0);
  endtask

  task automatic t_lock_hi;
    run_seq(8'hFF);
    expect_stat(19'h7FFF2, 8'hFF, "R3 R8 upper locked");
    expect_grant(1'b0, 11'd1984, 1'b0, "R6 sector 1984");
    expect_grant(1'b0, 11'd2047, 1'b0, "R6 sector 2047");
    expect_grant(1'b0, 11'd1983, 1'b1, "R6 sector 1983");
    expect_grant(1'b1, 11'd5, 1'b0, "R7 chip erase both");
  endtask

  task automatic t_sticky;
    run_seq(8'h5A);
    send(19'h00000, 8'h00);
    run_seq(8'h00);
    expect_stat(19'h00002, 8'hFF, "R10 lower stays");
    expect_stat(19'h7FFF2, 8'hFF, "R10 upper stays");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_stat(19'h00002, 8'hFE, "R10 reset clears lower");
    expect_stat(19'h7FFF2, 8'hFE, "R10 reset clears upper");
    expect_grant(1'b1, 11'd0, 1'b1, "R1 chip after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_broken();
    t_lock_lo();
    t_id_gate();
    t_lock_hi();
    t_sticky();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule